// File: doc/BRIEF.md
# Configurable Asynchronous Frame Transmitter

This block turns parallel characters into asynchronous serial frames on one output line. A character is accepted over a valid/ready handshake into a one-deep holding register. When the shift stage is free, the character moves into it. The frame then goes out as a low start bit, the data bits least significant first, an optional parity bit and a high stop period.

Each bit lasts a fixed number of ticks. A tick is a one-cycle enable pulse supplied from outside at the oversampling rate. The frame format comes from a line-control byte, which the block samples at the moment a character enters the shift stage. The format can therefore change between characters without harming a frame already on the line. A break bit in the same byte pulls the line low immediately for as long as it is set.

Two status flags report progress. One shows that the holding register can take a new character. The other shows that the transmitter has fully drained.

Top module: `async_frame_tx`

## Requirements
- R1: After reset, `serial_o`, `hold_empty_o`, `tx_empty_o` and `data_ready_o` are all 1.
- R2: A frame begins with a start bit of 0. Every bit lasts OVS ticks of `tick_i`, counted from the clock cycle after the character is loaded into the shift stage. A tick in the load cycle itself is not counted.
- R3: `lcr_i[1:0]` selects the word length: 00 gives 5 data bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits go out least significant first. Bits of `data_i` above the word length have no effect on the line.
- R4: With `lcr_i[3]`=1, a parity bit follows the data bits. With `lcr_i[4]`=1, the parity bit makes the number of ones in data plus parity even. With `lcr_i[4]`=0, it makes that number odd.
- R5: With `lcr_i[3]`=1 and `lcr_i[5]`=1, the parity bit is the inverse of `lcr_i[4]`, whatever the data.
- R6: With `lcr_i[2]`=0, the stop period lasts OVS ticks. With `lcr_i[2]`=1, it lasts 2*OVS ticks, except with 5-bit words, where it lasts 3*OVS/2 ticks. The line is 1 throughout the stop period.
- R7: While `lcr_i[6]`=1, `serial_o` is 0 in the same cycle, regardless of the shift stage.
- R8: `data_ready_o` equals `hold_empty_o`. A character is taken when `data_valid_i` and `data_ready_o` are both 1. `hold_empty_o` drops in the cycle after the character is taken. It returns to 1 one cycle later if the shift stage is idle.
- R9: `tx_empty_o` is 1 only when the holding register is empty and no frame is in progress. It rises in the cycle after the last stop tick.
- R10: The line-control byte is sampled when a character is loaded. Changing `lcr_i[5:0]` during a frame does not alter that frame.
- R11: A character waiting in the holding register starts its frame in the cycle after the previous stop period ends, with no idle tick in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable pulse at the oversampling rate |
| lcr_i | input | 8 | Line control: [1:0] word length, [2] long stop, [3] parity enable, [4] even select, [5] stick parity, [6] break |
| data_i | input | 8 | Character to send |
| data_valid_i | input | 1 | Character on `data_i` is valid |
| data_ready_o | output | 1 | Holding register can accept a character |
| serial_o | output | 1 | Serial line, idles high |
| hold_empty_o | output | 1 | Holding register empty |
| tx_empty_o | output | 1 | Holding register and shift stage both idle |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit and an 8-bit character path. This covers all four word lengths, both parity senses, stick parity in both polarities, and all three stop-period lengths, including the 24-tick half-extended stop of 5-bit words.

The tick pulse arrives every fourth clock. This leaves a gap between load and the first counted tick, so an off-by-one in tick counting or in the end of a frame shows up as a shifted bit boundary. Back-to-back frames exercise the handover from holding register to shift stage. A line-control change in mid-frame checks that the format is latched per character.

// File: rtl/tx_frame_pkg.sv
package tx_frame_pkg;
  localparam int unsigned MAX_BITS = 8;
  localparam int unsigned NBW      = $clog2(MAX_BITS + 1);
  localparam int unsigned IW       = $clog2(MAX_BITS);

  typedef struct packed {
    logic [NBW-1:0] nbits;
    logic           par_en;
    logic           par_even;
    logic           par_stick;
    logic [2:0]     stop_halves;  // stop period in half-bits: 2, 3 or 4
  } frame_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;
endpackage

// File: rtl/tx_lcr_decode.sv
module tx_lcr_decode
  import tx_frame_pkg::*;
(
  input  logic [7:0]  lcr_i,
  output frame_cfg_t  cfg_o,
  output logic        brk_o
);
  always_comb begin
    cfg_o.nbits     = NBW'(5) + NBW'(lcr_i[1:0]);
    cfg_o.par_en    = lcr_i[3];
    cfg_o.par_even  = lcr_i[4];
    cfg_o.par_stick = lcr_i[5];
    if (!lcr_i[2])             cfg_o.stop_halves = 3'd2;
    else if (lcr_i[1:0] == 2'b00) cfg_o.stop_halves = 3'd3;
    else                       cfg_o.stop_halves = 3'd4;
  end
  assign brk_o = lcr_i[6];
endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (valid_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= data_i;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;

  assert_empty_by_take_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_q) |-> $past(take_i));
  assert_fill_by_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> $past(valid_i));
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import tx_frame_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                load_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  frame_cfg_t          cfg_i,
  output logic                idle_o,
  output logic                line_o
);
  localparam int unsigned CW = $clog2(2 * OVS) + 1;
  localparam logic [CW-1:0] BIT_LEN = CW'(OVS);
  localparam logic [CW-1:0] STOP_1  = CW'(OVS);
  localparam logic [CW-1:0] STOP_15 = CW'(OVS + OVS / 2);
  localparam logic [CW-1:0] STOP_2  = CW'(2 * OVS);

  tx_state_e            state_q;
  frame_cfg_t           cfg_q;
  logic [MAX_BITS-1:0]  sh_q;
  logic [IW-1:0]        idx_q;
  logic [CW-1:0]        cnt_q;
  logic [CW-1:0]        stop_len_q;
  logic                 par_q;

  logic [MAX_BITS-1:0]  masked;
  logic                 par_new;
  logic [CW-1:0]        stop_len_new;
  logic [CW-1:0]        cur_len;
  logic                 last_tick;
  logic                 last_data;

  assign masked = data_i & ({MAX_BITS{1'b1}} >> (MAX_BITS - int'(cfg_i.nbits)));

  always_comb begin
    if (cfg_i.par_stick)     par_new = ~cfg_i.par_even;
    else if (cfg_i.par_even) par_new = ^masked;
    else                     par_new = ~(^masked);
    case (cfg_i.stop_halves)
      3'd3:    stop_len_new = STOP_15;
      3'd4:    stop_len_new = STOP_2;
      default: stop_len_new = STOP_1;
    endcase
  end

  assign cur_len   = (state_q == ST_STOP) ? stop_len_q : BIT_LEN;
  assign last_tick = tick_i && (cnt_q == cur_len - CW'(1));
  assign last_data = ({{(NBW - IW){1'b0}}, idx_q} == cfg_q.nbits - NBW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cfg_q      <= '0;
      sh_q       <= '0;
      idx_q      <= '0;
      cnt_q      <= '0;
      stop_len_q <= STOP_1;
      par_q      <= 1'b0;
    end else if (load_i && state_q == ST_IDLE) begin
      state_q    <= ST_START;
      cfg_q      <= cfg_i;
      sh_q       <= masked;
      idx_q      <= '0;
      cnt_q      <= '0;
      stop_len_q <= stop_len_new;
      par_q      <= par_new;
    end else if (tick_i && state_q != ST_IDLE) begin
      if (!last_tick) begin
        cnt_q <= cnt_q + CW'(1);
      end else begin
        cnt_q <= '0;
        unique case (state_q)
          ST_START: state_q <= ST_DATA;
          ST_DATA: begin
            sh_q <= sh_q >> 1;
            if (last_data) state_q <= cfg_q.par_en ? ST_PARITY : ST_STOP;
            else           idx_q   <= idx_q + IW'(1);
          end
          ST_PARITY: state_q <= ST_STOP;
          ST_STOP:   state_q <= ST_IDLE;
          default:   state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START:  line_o = 1'b0;
      ST_DATA:   line_o = sh_q[0];
      ST_PARITY: line_o = par_q;
      default:   line_o = 1'b1;
    endcase
  end

  assign idle_o = (state_q == ST_IDLE);

  assert_stop_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP) |-> line_o);
  assert_idx_in_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> ({{(NBW - IW){1'b0}}, idx_q} < cfg_q.nbits));
  assert_no_tick_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !tick_i) |=> ($stable(state_q) && $stable(cnt_q)));
  assert_cnt_in_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> (cnt_q < cur_len));
  assert_parity_only_enabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PARITY) |-> cfg_q.par_en);
endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
  import tx_frame_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [7:0]          lcr_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic                data_valid_i,
  output logic                data_ready_o,
  output logic                serial_o,
  output logic                hold_empty_o,
  output logic                tx_empty_o
);
  frame_cfg_t          cfg;
  logic                brk;
  logic                hold_full;
  logic [MAX_BITS-1:0] hold_data;
  logic                sh_idle;
  logic                sh_line;
  logic                take;

  tx_lcr_decode u_decode (
    .lcr_i (lcr_i),
    .cfg_o (cfg),
    .brk_o (brk)
  );

  tx_hold_reg #(.DATA_W(MAX_BITS)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (data_valid_i),
    .data_i  (data_i),
    .take_i  (take),
    .data_o  (hold_data),
    .full_o  (hold_full)
  );

  assign take = hold_full && sh_idle;

  tx_shifter #(.OVS(OVS)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .load_i (take),
    .data_i (hold_data),
    .cfg_i  (cfg),
    .idle_o (sh_idle),
    .line_o (sh_line)
  );

  assign serial_o     = sh_line & ~brk;
  assign hold_empty_o = ~hold_full;
  assign data_ready_o = ~hold_full;
  assign tx_empty_o   = ~hold_full & sh_idle;

  assert_idle_line_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty_o && !lcr_i[6]) |-> serial_o);
  assert_empty_implies_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> hold_empty_o);
  assert_start_after_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !lcr_i[6]) |=> !serial_o || lcr_i[6]);
endmodule

// File: tb/tb_async_frame_tx.sv
module tb_async_frame_tx;
  localparam int OVS = 16;

  typedef struct {
    logic [7:0] d;
    logic [7:0] lcr;
    string      tag;
  } frame_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i;
  logic [7:0] lcr_i = 8'h03;
  logic [7:0] data_i = 8'h00;
  logic       data_valid_i = 1'b0;
  logic       data_ready_o, serial_o, hold_empty_o, tx_empty_o;

  int     n_checks = 0;
  int     n_fail = 0;
  bit     brk_test = 1'b0;
  bit     done = 1'b0;
  bit     gap_expect = 1'b0;
  frame_t exp_q[$];
  logic [1:0] tick_cnt;

  always #2 clk_i = ~clk_i;

  async_frame_tx #(.OVS(OVS)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .lcr_i(lcr_i),
    .data_i(data_i), .data_valid_i(data_valid_i), .data_ready_o(data_ready_o),
    .serial_o(serial_o), .hold_empty_o(hold_empty_o), .tx_empty_o(tx_empty_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_cnt <= '0;
      tick_i   <= 1'b0;
    end else begin
      tick_cnt <= tick_cnt + 2'd1;
      tick_i   <= (tick_cnt == 2'd3);
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int nbits_of(logic [7:0] l);
    return 5 + int'(l[1:0]);
  endfunction

  function automatic int frame_len(logic [7:0] l);
    int n = nbits_of(l);
    int s = !l[2] ? OVS : (n == 5 ? OVS + OVS / 2 : 2 * OVS);
    return OVS * (1 + n + int'(l[3])) + s;
  endfunction

  function automatic logic exp_bit(int k, frame_t f);
    int n = nbits_of(f.lcr);
    int b = k / OVS;
    logic p = ^(f.d & ((8'hFF) >> (8 - n)));
    if (b == 0) return 1'b0;
    if (b <= n) return f.d[b-1];
    if (f.lcr[3] && b == n + 1) begin
      if (f.lcr[5]) return ~f.lcr[4];
      return f.lcr[4] ? p : ~p;
    end
    return 1'b1;
  endfunction

  function automatic string region_tag(int k, frame_t f);
    int n = nbits_of(f.lcr);
    int b = k / OVS;
    if (f.tag != "") return f.tag;
    if (b == 0) return "R2";
    if (b <= n) return "R3";
    if (f.lcr[3] && b == n + 1) return f.lcr[5] ? "R5" : "R4";
    return "R6";
  endfunction

  task automatic send(input logic [7:0] d, input logic [7:0] l, input string tag);
    frame_t f;
    @(negedge clk_i);
    while (!data_ready_o) @(negedge clk_i);
    data_i = d;
    lcr_i = l;
    data_valid_i = 1'b1;
    @(posedge clk_i);
    f.d = d; f.lcr = l; f.tag = tag;
    exp_q.push_back(f);
    @(negedge clk_i);
    data_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk_i);
    while (exp_q.size() != 0 || !tx_empty_o) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  // scoreboard monitor
  initial begin : monitor
    logic prev_line;
    logic prev_tick;
    frame_t f;
    int k;
    int len;
    prev_line = 1'b1;
    forever begin
      @(negedge clk_i);
      if (gap_expect) begin
        gap_expect = 1'b0;
        check("R11", serial_o, 1'b0);
      end
      if (rst_ni && !brk_test && prev_line && !serial_o) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected start", 1, 0);
        end else begin
          f = exp_q.pop_front();
          len = frame_len(f.lcr);
          k = 0;
          prev_tick = tick_i;
          while (k < len) begin
            @(negedge clk_i);
            if (prev_tick) begin
              k++;
              if (k < len && (k % OVS) == OVS / 2)
                check(region_tag(k, f), serial_o, exp_bit(k, f));
              if (k == len - 1)
                check((f.tag != "") ? f.tag : "R6", tx_empty_o, 1'b0);
              if (k == len) begin
                check("R9", serial_o, 1'b1);
                check("R9", tx_empty_o, (exp_q.size() == 0));
                if (exp_q.size() != 0) gap_expect = 1'b1;
              end
            end
            prev_tick = tick_i;
          end
        end
      end
      prev_line = serial_o;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1", serial_o, 1'b1);
    check("R1", hold_empty_o, 1'b1);
    check("R1", tx_empty_o, 1'b1);
    check("R1", data_ready_o, 1'b1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R8 handshake timing
    data_i = 8'h3C; lcr_i = 8'h03; data_valid_i = 1'b1;
    @(posedge clk_i);
    begin
      frame_t f;
      f.d = 8'h3C; f.lcr = 8'h03; f.tag = "";
      exp_q.push_back(f);
    end
    @(negedge clk_i);
    data_valid_i = 1'b0;
    check("R8", hold_empty_o, 1'b0);
    check("R8", data_ready_o, 1'b0);
    @(negedge clk_i);
    check("R8", hold_empty_o, 1'b1);
    check("R9", tx_empty_o, 1'b0);
    wait_idle();

    // formats
    send(8'hA5, 8'h03, "");          // 8N1
    wait_idle();
    send(8'h96, 8'h1A, "");          // 7 bits, even parity
    wait_idle();
    send(8'h2B, 8'h0D, "");          // 6 bits, odd parity, 2 stop
    wait_idle();
    send(8'hE0, 8'h04, "");          // 5 bits, 1.5 stop, high bits ignored (R3)
    wait_idle();
    send(8'h5F, 8'h00, "");          // 5 bits, 1 stop
    wait_idle();
    send(8'h81, 8'h3B, "");          // stick parity, even-select -> 0 (R5)
    wait_idle();
    send(8'h80, 8'h2B, "");          // stick parity, odd-select -> 1 (R5)
    wait_idle();
    send(8'h07, 8'h09, "");          // 6 bits odd parity
    wait_idle();

    // R10 mid-frame format change
    send(8'h5A, 8'h03, "R10");
    while (exp_q.size() != 0) @(negedge clk_i);
    repeat (60) @(negedge clk_i);
    lcr_i = 8'h1C;
    wait_idle();

    // R11 back-to-back frames with different formats
    send(8'hC3, 8'h0B, "");
    send(8'h11, 8'h04, "");
    send(8'hFE, 8'h1F, "");
    wait_idle();

    // R7 break
    brk_test = 1'b1;
    lcr_i = 8'h43;
    #1;
    check("R7", serial_o, 1'b0);
    repeat (5) @(negedge clk_i);
    check("R7", serial_o, 1'b0);
    lcr_i = 8'h03;
    #1;
    check("R7", serial_o, 1'b1);
    repeat (2) @(negedge clk_i);
    brk_test = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R9", tx_empty_o, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule